// File: doc/BRIEF.md
# I2C Target to Register Bus Bridge

This block converts the byte events of an I2C target engine into accesses on the 32-bit register bus of a security module's status and FIFO interface. The engine reports a write-start, a stop, each received byte (and waits for an ACK or NAK decision) and each read-byte request (and waits for the byte to send). The bridge turns these events into reads and writes on the register bus, each with an address, a byte size and data.

The first byte of a write transaction selects a register index. The bridge decodes the index and keeps two small registers of its own: the locality select and the checksum-enable bit. It collects multi-byte register writes in a five-byte buffer and commits them at the stop condition. FIFO bytes pass straight through, one backend access per byte. Register reads are fetched once and then handed out byte by byte. For the status register the bridge handles sub-word access, masks and byte-lane shifts in both directions. While a backend access is pending, the engine is held through `i2c_busy`, and the reply to the current byte is withheld.

Top module: `sec_i2c_regbridge`

## Requirements
- R1: The first byte after a write-start is taken as a register index. The mapped indices 0x00, 0x04, 0x08, 0x14, 0x18 to 0x1B, 0x24, 0x30, 0x40, 0x48 and 0x4C are answered with ACK (`i2c_rx_nak`=0). Any other index, and the address-change index 0x38, is answered with NAK.
- R2: Every backend address equals the register's base offset plus the locality shifted left by 12. The base offsets are 0x04→0x000, 0x08→0x008, 0x18→0x018, 0x24→0x024, 0x30→0x014, 0x48→0xF00 and 0x4C→0xF04.
- R3: For non-FIFO indices, up to four data bytes are stored little-endian. At stop, one backend write (`bus_size`=4) is issued, but only if at least one data byte arrived. A fifth data byte is answered with NAK.
- R4: Each data byte written to index 0x24 becomes its own backend write with `bus_size`=1 and the byte in `bus_wdata[7:0]`. The byte's ACK is given only after that write has been acknowledged.
- R5: Index 0x00 is the locality register and is held inside the bridge. A written value from 0 to 4 is stored; any other value is ignored. Reading index 0x00 returns the stored value.
- R6: A status write at index 0x18 is a 4-byte write to base 0x018. A write at 0x18+k (k from 1 to 3) is a 1-byte write to 0x018+k. In both cases the data is ANDed with 0x030000FE shifted right by 8·k.
- R7: On a status read at 0x18+k, the backend value has bits 31:26 forced to zero and is then shifted right by 8·k before it is returned.
- R8: A non-FIFO read issues one 4-byte backend read and returns its bytes least significant first. Reads past those four bytes return 0x00. Every read byte of index 0x24 issues a fresh 1-byte backend read.
- R9: Index 0x40 stores only bit 0 of the written byte, and a read returns that bit. Reads of index 0x14 return 0x00000087. Writes to index 0x08 are ANDed with 0x00000087.
- R10: A read of index 0x30 returns 0x1A000702. Bit 29 is also set when bit 8 of the backend value is set.
- R11: A stop that ends a read clears the transaction, and so does every write-start. A stop after only an index byte keeps that index for a following read. A read with no index returns 0x00. When stop and write-start arrive in the same cycle, the buffered write is committed first and the transaction is cleared afterwards.
- R12: After reset the locality is 0, checksum-enable is 0, `bus_req` is low and `i2c_busy` is low.
- R13: `bus_req` and its address, size, write-enable and data stay stable until `bus_ack`. `i2c_busy` is high while an access is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i2c_wr_start | input | 1 | Write-start event pulse |
| i2c_stop | input | 1 | Stop event pulse |
| i2c_rx_valid | input | 1 | Received byte pulse |
| i2c_rx_byte | input | 8 | Received byte value |
| i2c_rx_done | output | 1 | Reply to the received byte is ready |
| i2c_rx_nak | output | 1 | Reply is NAK (valid with i2c_rx_done) |
| i2c_rd_req | input | 1 | Read-byte request pulse |
| i2c_rd_done | output | 1 | Read byte is ready |
| i2c_rd_byte | output | 8 | Byte to transmit |
| i2c_busy | output | 1 | Backend access pending; engine holds |
| bus_req | output | 1 | Backend request, held until ack |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 16 | Backend byte address |
| bus_size | output | 3 | Access size in bytes (1 or 4) |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Backend completion |

## Verification
The stop event, which commits buffered register bytes to the backend, and the write-start event, which wipes the transaction, can arrive in the same cycle when a new transaction follows a stop with no gap. The bench buffers one byte for index 0x04 and then raises both events in a single cycle. It expects exactly one backend write of size 4 that carries that byte at address 0x000. It then checks that the state was cleared: a read with no index returns 0x00, and a fresh index is accepted.

// File: rtl/sib_pkg.sv
package sib_pkg;
  localparam int BUF_BYTES = 5;
  localparam int NUM_LOC   = 5;
  localparam int LOC_SHIFT = 12;
  localparam int ADDR_W    = 16;

  typedef enum logic [3:0] {
    K_NONE, K_LOCSEL, K_ACCESS, K_INTEN, K_INTCAP, K_STS, K_FIFO,
    K_IFCAP, K_DEVADDR, K_CSUMEN, K_DIDVID, K_RID
  } reg_kind_e;

  typedef enum logic [1:0] {OP_IDLE, OP_SEND, OP_RECV} op_e;
  typedef enum logic [1:0] {P_FIFO_WR, P_REG_WR, P_FIFO_RD, P_REG_RD} purp_e;

  localparam logic [7:0] IX_LOCSEL = 8'h00;
  localparam logic [7:0] IX_ACCESS = 8'h04;
  localparam logic [7:0] IX_INTEN  = 8'h08;
  localparam logic [7:0] IX_INTCAP = 8'h14;
  localparam logic [7:0] IX_STS    = 8'h18;
  localparam logic [7:0] IX_FIFO   = 8'h24;
  localparam logic [7:0] IX_IFCAP  = 8'h30;
  localparam logic [7:0] IX_DEVADR = 8'h38;
  localparam logic [7:0] IX_CSUMEN = 8'h40;
  localparam logic [7:0] IX_DIDVID = 8'h48;
  localparam logic [7:0] IX_RID    = 8'h4C;

  localparam logic [11:0] BO_ACCESS = 12'h000;
  localparam logic [11:0] BO_INTEN  = 12'h008;
  localparam logic [11:0] BO_IFCAP  = 12'h014;
  localparam logic [11:0] BO_STS    = 12'h018;
  localparam logic [11:0] BO_FIFO   = 12'h024;
  localparam logic [11:0] BO_DIDVID = 12'hF00;
  localparam logic [11:0] BO_RID    = 12'hF04;

  localparam logic [31:0] INT_MASK    = 32'h0000_0087;
  localparam logic [31:0] STS_WMASK   = 32'h0300_00FE;
  localparam logic [31:0] STS_RMASK   = 32'h03FF_FFFF;
  localparam logic [31:0] IFCAP_BASE  = 32'h1A00_0702;
  localparam logic [31:0] IFCAP_BURST = 32'h2000_0000;
  localparam int          BE_BURST_BIT = 8;

  function automatic logic [31:0] sts_wr_value(logic [31:0] d, logic [1:0] lane);
    return d & (STS_WMASK >> (8 * lane));
  endfunction

  function automatic logic [31:0] sts_rd_value(logic [31:0] raw, logic [1:0] lane);
    return (raw & STS_RMASK) >> (8 * lane);
  endfunction

  function automatic logic [31:0] ifcap_value(logic [31:0] raw);
    return IFCAP_BASE | (raw[BE_BURST_BIT] ? IFCAP_BURST : 32'h0);
  endfunction

  function automatic logic [ADDR_W-1:0] bus_address(logic [11:0] base, logic [2:0] loc);
    return ADDR_W'(base) + (ADDR_W'(loc) << LOC_SHIFT);
  endfunction
endpackage

// File: rtl/sib_index_decode.sv
module sib_index_decode
  import sib_pkg::*;
(
  input  logic [7:0]  idx,
  output reg_kind_e   kind,
  output logic [11:0] base,
  output logic [1:0]  lane,
  output logic        mapped
);
  always_comb begin
    kind = K_NONE;
    base = 12'h000;
    lane = 2'd0;
    if (idx[7:2] == IX_STS[7:2]) begin
      kind = K_STS;
      base = BO_STS;
      lane = idx[1:0];
    end else begin
      unique case (idx)
        IX_LOCSEL: kind = K_LOCSEL;
        IX_ACCESS: begin kind = K_ACCESS; base = BO_ACCESS; end
        IX_INTEN:  begin kind = K_INTEN;  base = BO_INTEN;  end
        IX_INTCAP: kind = K_INTCAP;
        IX_FIFO:   begin kind = K_FIFO;   base = BO_FIFO;   end
        IX_IFCAP:  begin kind = K_IFCAP;  base = BO_IFCAP;  end
        IX_DEVADR: kind = K_DEVADDR;
        IX_CSUMEN: kind = K_CSUMEN;
        IX_DIDVID: begin kind = K_DIDVID; base = BO_DIDVID; end
        IX_RID:    begin kind = K_RID;    base = BO_RID;    end
        default:   kind = K_NONE;
      endcase
    end
    mapped = (kind != K_NONE) && (kind != K_DEVADDR);
  end
endmodule

// File: rtl/sib_byte_buf.sv
module sib_byte_buf #(
  parameter int NBYTES = 5,
  localparam int SEL_W = $clog2(NBYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   wr_en,
  input  logic [SEL_W-1:0]       wr_sel,
  input  logic [7:0]             wr_byte,
  input  logic                   fill_en,
  input  logic [31:0]            fill_word,
  output logic [NBYTES-1:0][7:0] bytes_o
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    if (i >= 1 && i <= 4) begin : g_word_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                bytes_o[i] <= 8'h00;
        else if (clr)                              bytes_o[i] <= 8'h00;
        else if (fill_en)                          bytes_o[i] <= fill_word[8*(i-1) +: 8];
        else if (wr_en && wr_sel == SEL_W'(i))     bytes_o[i] <= wr_byte;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                bytes_o[i] <= 8'h00;
        else if (clr)                              bytes_o[i] <= 8'h00;
        else if (wr_en && wr_sel == SEL_W'(i))     bytes_o[i] <= wr_byte;
      end
    end
  end
endmodule

// File: rtl/sib_bus_port.sv
module sib_bus_port #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_we,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [2:0]        go_size,
  input  logic [31:0]       go_wdata,
  input  logic              ack,
  output logic              req,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [2:0]        size,
  output logic [31:0]       wdata,
  output logic              done
);
  assign done = req & ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req   <= 1'b0;
      we    <= 1'b0;
      addr  <= '0;
      size  <= 3'd0;
      wdata <= 32'h0;
    end else if (go) begin
      req   <= 1'b1;
      we    <= go_we;
      addr  <= go_addr;
      size  <= go_size;
      wdata <= go_wdata;
    end else if (done) begin
      req   <= 1'b0;
    end
  end
endmodule

// File: rtl/sec_i2c_regbridge.sv
module sec_i2c_regbridge
  import sib_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i2c_wr_start,
  input  logic              i2c_stop,
  input  logic              i2c_rx_valid,
  input  logic [7:0]        i2c_rx_byte,
  output logic              i2c_rx_done,
  output logic              i2c_rx_nak,
  input  logic              i2c_rd_req,
  output logic              i2c_rd_done,
  output logic [7:0]        i2c_rd_byte,
  output logic              i2c_busy,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [2:0]        bus_size,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_ack
);
  localparam int CNT_W = $clog2(BUF_BYTES + 1);
  localparam int SEL_W = $clog2(BUF_BYTES);

  typedef enum logic {ST_IDLE, ST_WAIT} st_e;

  st_e        state_q, nxt_state;
  purp_e      purp_q, nxt_purp;
  op_e        op_q, nxt_op;
  logic [CNT_W-1:0] cnt_q, nxt_cnt;
  logic [2:0] loc_q, nxt_loc;
  logic       csum_q, nxt_csum;
  logic       rx_done_q, rx_done_n, rx_nak_q, rx_nak_n;
  logic       rd_done_q, rd_done_n;
  logic [7:0] rd_byte_q, rd_byte_n;

  logic [BUF_BYTES-1:0][7:0] bytes_q;
  logic             buf_clr, buf_wr, buf_fill;
  logic [SEL_W-1:0] buf_sel;
  logic [31:0]      fill_word;

  logic              go, go_we;
  logic [ADDR_W-1:0] go_addr;
  logic [2:0]        go_size;
  logic [31:0]       go_wdata;
  logic              bus_done;

  reg_kind_e   cur_kind, new_kind;
  logic [11:0] cur_base, new_base;
  logic [1:0]  cur_lane, new_lane;
  logic        cur_mapped, new_mapped;

  // Named internal events for the checker
  logic ev_commit, ev_fifo_push, ev_clear;

  logic [31:0] wr_word;
  assign wr_word = {bytes_q[4], bytes_q[3], bytes_q[2], bytes_q[1]};

  sib_index_decode u_dec_cur (
    .idx(bytes_q[0]), .kind(cur_kind), .base(cur_base), .lane(cur_lane), .mapped(cur_mapped)
  );
  sib_index_decode u_dec_new (
    .idx(i2c_rx_byte), .kind(new_kind), .base(new_base), .lane(new_lane), .mapped(new_mapped)
  );

  sib_byte_buf #(.NBYTES(BUF_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(buf_wr), .wr_sel(buf_sel),
    .wr_byte(i2c_rx_byte), .fill_en(buf_fill), .fill_word(fill_word), .bytes_o(bytes_q)
  );

  sib_bus_port #(.ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst_n(rst_n), .go(go), .go_we(go_we), .go_addr(go_addr),
    .go_size(go_size), .go_wdata(go_wdata), .ack(bus_ack), .req(bus_req),
    .we(bus_we), .addr(bus_addr), .size(bus_size), .wdata(bus_wdata), .done(bus_done)
  );

  function automatic logic [31:0] shape_read(reg_kind_e k, logic [1:0] lane, logic [31:0] raw);
    unique case (k)
      K_STS:   return sts_rd_value(raw, lane);
      K_IFCAP: return ifcap_value(raw);
      default: return raw;
    endcase
  endfunction

  always_comb begin
    nxt_state = state_q;
    nxt_purp  = purp_q;
    nxt_op    = op_q;
    nxt_cnt   = cnt_q;
    nxt_loc   = loc_q;
    nxt_csum  = csum_q;
    rx_done_n = 1'b0;
    rx_nak_n  = 1'b0;
    rd_done_n = 1'b0;
    rd_byte_n = rd_byte_q;
    buf_clr   = 1'b0;
    buf_wr    = 1'b0;
    buf_sel   = SEL_W'(cnt_q);
    buf_fill  = 1'b0;
    fill_word = 32'h0;
    go        = 1'b0;
    go_we     = 1'b0;
    go_addr   = '0;
    go_size   = 3'd0;
    go_wdata  = 32'h0;
    ev_commit = 1'b0;
    ev_fifo_push = 1'b0;
    ev_clear  = 1'b0;

    if (state_q == ST_IDLE) begin
      if (i2c_stop) begin
        if (op_q == OP_SEND && cnt_q > CNT_W'(1)) begin
          unique case (cur_kind)
            K_CSUMEN: begin nxt_csum = bytes_q[1][0]; ev_clear = 1'b1; end
            K_LOCSEL: begin
              if (bytes_q[1] < 8'(NUM_LOC)) nxt_loc = bytes_q[1][2:0];
              ev_clear = 1'b1;
            end
            K_FIFO:   ev_clear = 1'b1;
            default: begin
              ev_commit = 1'b1;
              go        = 1'b1;
              go_we     = 1'b1;
              go_addr   = bus_address(cur_base + ((cur_kind == K_STS) ? 12'(cur_lane) : 12'h0), loc_q);
              go_size   = (cur_kind == K_STS && cur_lane != 2'd0) ? 3'd1 : 3'd4;
              if (cur_kind == K_STS)        go_wdata = sts_wr_value(wr_word, cur_lane);
              else if (cur_kind == K_INTEN) go_wdata = wr_word & INT_MASK;
              else                          go_wdata = wr_word;
              nxt_state = ST_WAIT;
              nxt_purp  = P_REG_WR;
            end
          endcase
        end else if (!(op_q == OP_SEND && !i2c_wr_start)) begin
          ev_clear = 1'b1;
        end
      end else if (i2c_wr_start) begin
        ev_clear = 1'b1;
      end else if (i2c_rx_valid) begin
        rx_done_n = 1'b1;
        if (cnt_q == '0) begin
          if (new_mapped) begin
            buf_wr  = 1'b1;
            nxt_cnt = CNT_W'(1);
            nxt_op  = OP_SEND;
          end else begin
            rx_nak_n = 1'b1;
          end
        end else if (cnt_q < CNT_W'(BUF_BYTES)) begin
          nxt_op = OP_SEND;
          if (cur_kind == K_FIFO) begin
            rx_done_n    = 1'b0;
            ev_fifo_push = 1'b1;
            go        = 1'b1;
            go_we     = 1'b1;
            go_addr   = bus_address(cur_base, loc_q);
            go_size   = 3'd1;
            go_wdata  = {24'h0, i2c_rx_byte};
            nxt_state = ST_WAIT;
            nxt_purp  = P_FIFO_WR;
          end else begin
            buf_wr  = 1'b1;
            nxt_cnt = cnt_q + CNT_W'(1);
          end
        end else begin
          rx_nak_n = 1'b1;
        end
      end else if (i2c_rd_req) begin
        rd_done_n = 1'b1;
        if (op_q == OP_RECV) begin
          if (cur_kind == K_FIFO) begin
            rd_done_n = 1'b0;
            go        = 1'b1;
            go_addr   = bus_address(cur_base, loc_q);
            go_size   = 3'd1;
            nxt_state = ST_WAIT;
            nxt_purp  = P_FIFO_RD;
          end else if (cnt_q < CNT_W'(BUF_BYTES)) begin
            rd_byte_n = bytes_q[SEL_W'(cnt_q)];
            nxt_cnt   = cnt_q + CNT_W'(1);
          end else begin
            rd_byte_n = 8'h00;
          end
        end else if (op_q == OP_SEND && cnt_q == CNT_W'(1)) begin
          nxt_op = OP_RECV;
          unique case (cur_kind)
            K_LOCSEL: fill_word = {29'h0, loc_q};
            K_CSUMEN: fill_word = {31'h0, csum_q};
            K_INTCAP: fill_word = INT_MASK;
            default:  fill_word = 32'h0;
          endcase
          if (cur_kind == K_LOCSEL || cur_kind == K_CSUMEN || cur_kind == K_INTCAP) begin
            buf_fill  = 1'b1;
            rd_byte_n = fill_word[7:0];
            nxt_cnt   = CNT_W'(2);
          end else begin
            rd_done_n = 1'b0;
            go        = 1'b1;
            go_addr   = bus_address(cur_base, loc_q);
            go_size   = (cur_kind == K_FIFO) ? 3'd1 : 3'd4;
            nxt_state = ST_WAIT;
            nxt_purp  = (cur_kind == K_FIFO) ? P_FIFO_RD : P_REG_RD;
          end
        end else begin
          nxt_op    = OP_RECV;
          rd_byte_n = 8'h00;
        end
      end
    end else if (bus_done) begin
      nxt_state = ST_IDLE;
      unique case (purp_q)
        P_FIFO_WR: rx_done_n = 1'b1;
        P_REG_WR:  ev_clear  = 1'b1;
        P_FIFO_RD: begin rd_done_n = 1'b1; rd_byte_n = bus_rdata[7:0]; end
        P_REG_RD: begin
          fill_word = shape_read(cur_kind, cur_lane, bus_rdata);
          buf_fill  = 1'b1;
          rd_byte_n = fill_word[7:0];
          rd_done_n = 1'b1;
          nxt_cnt   = CNT_W'(2);
        end
      endcase
    end

    if (ev_clear) begin
      buf_clr = 1'b1;
      nxt_cnt = '0;
      nxt_op  = OP_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      purp_q    <= P_FIFO_WR;
      op_q      <= OP_IDLE;
      cnt_q     <= '0;
      loc_q     <= 3'd0;
      csum_q    <= 1'b0;
      rx_done_q <= 1'b0;
      rx_nak_q  <= 1'b0;
      rd_done_q <= 1'b0;
      rd_byte_q <= 8'h00;
    end else begin
      state_q   <= nxt_state;
      purp_q    <= nxt_purp;
      op_q      <= nxt_op;
      cnt_q     <= nxt_cnt;
      loc_q     <= nxt_loc;
      csum_q    <= nxt_csum;
      rx_done_q <= rx_done_n;
      rx_nak_q  <= rx_nak_n;
      rd_done_q <= rd_done_n;
      rd_byte_q <= rd_byte_n;
    end
  end

  assign i2c_rx_done = rx_done_q;
  assign i2c_rx_nak  = rx_nak_q;
  assign i2c_rd_done = rd_done_q;
  assign i2c_rd_byte = rd_byte_q;
  assign i2c_busy    = (state_q == ST_WAIT);
endmodule

// File: rtl/sib_checker.sv
module sib_checker
  import sib_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              i2c_wr_start,
  input logic              i2c_stop,
  input logic              i2c_busy,
  input logic              i2c_rx_done,
  input logic              i2c_rx_nak,
  input logic              bus_req,
  input logic              bus_ack,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [2:0]        bus_size,
  input logic [31:0]       bus_wdata,
  input logic [3:0]        fill_cnt,
  input logic [2:0]        loc_sel,
  input logic              ev_fifo_push
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_size)
                            && $stable(bus_we) && $stable(bus_wdata)); // R13

  AST_BUSY_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> i2c_busy); // R13

  AST_NAK_HAS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    i2c_rx_nak |-> i2c_rx_done); // R1

  AST_LOC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_addr >> LOC_SHIFT) < NUM_LOC); // R5

  AST_FIFO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fifo_push |=> bus_req && bus_we && bus_size == 3'd1 && !i2c_rx_done); // R4

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    i2c_wr_start && !i2c_stop && !i2c_busy |=> fill_cnt == 4'd0); // R11

  AST_LOC_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    loc_sel < 3'(NUM_LOC)); // R5
endmodule

bind sec_i2c_regbridge sib_checker u_chk (
  .clk(clk), .rst_n(rst_n), .i2c_wr_start(i2c_wr_start), .i2c_stop(i2c_stop),
  .i2c_busy(i2c_busy), .i2c_rx_done(i2c_rx_done), .i2c_rx_nak(i2c_rx_nak),
  .bus_req(bus_req), .bus_ack(bus_ack), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_size(bus_size), .bus_wdata(bus_wdata), .fill_cnt(4'(cnt_q)),
  .loc_sel(loc_q), .ev_fifo_push(ev_fifo_push)
);

// File: tb/sec_i2c_regbridge_tb_top.sv
`timescale 1ns/1ps
module sec_i2c_regbridge_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic i2c_wr_start = 0, i2c_stop = 0, i2c_rx_valid = 0, i2c_rd_req = 0;
  logic [7:0] i2c_rx_byte = 8'h00;
  logic i2c_rx_done, i2c_rx_nak, i2c_rd_done, i2c_busy;
  logic [7:0] i2c_rd_byte;
  logic bus_req, bus_we, bus_ack;
  logic [15:0] bus_addr;
  logic [2:0] bus_size;
  logic [31:0] bus_wdata, bus_rdata;

  sec_i2c_regbridge dut_i (.*);

  // Backend model: acks after a short wait, logs writes, counts reads
  logic [31:0] be_val = 32'h0;
  logic [7:0]  fifo_seq = 8'h60;
  logic [1:0]  wait_c = 0;
  int n_wr = 0, n_rd = 0;
  logic [15:0] w_addr;
  logic [2:0]  w_size;
  logic [31:0] w_data;
  initial begin bus_ack = 0; bus_rdata = 0; end
  always @(posedge clk) begin
    bus_ack <= 1'b0;
    if (bus_req && !bus_ack) begin
      if (wait_c == 2'd2) begin
        wait_c  <= 0;
        bus_ack <= 1'b1;
        if (bus_we) begin
          n_wr <= n_wr + 1; w_addr <= bus_addr; w_size <= bus_size; w_data <= bus_wdata;
        end else begin
          n_rd <= n_rd + 1;
          if (bus_addr[11:0] == 12'h024) begin bus_rdata <= {24'h0, fifo_seq}; fifo_seq <= fifo_seq + 1; end
          else bus_rdata <= be_val;
        end
      end else wait_c <= wait_c + 1;
    end
  end

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    while (i2c_busy) @(negedge clk);
  endtask

  task automatic wstart();
    @(negedge clk); i2c_wr_start = 1;
    @(negedge clk); i2c_wr_start = 0;
  endtask

  task automatic stop_ev();
    @(negedge clk); i2c_stop = 1;
    @(negedge clk); i2c_stop = 0;
    while (i2c_busy) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, output logic nak);
    @(negedge clk); i2c_rx_valid = 1; i2c_rx_byte = b;
    @(negedge clk); i2c_rx_valid = 0;
    while (!i2c_rx_done) @(negedge clk);
    nak = i2c_rx_nak;
  endtask

  task automatic rd(output logic [7:0] b);
    @(negedge clk); i2c_rd_req = 1;
    @(negedge clk); i2c_rd_req = 0;
    while (!i2c_rd_done) @(negedge clk);
    b = i2c_rd_byte;
  endtask

  task automatic read_reg(input logic [7:0] idx, output logic [31:0] v);
    logic n; logic [7:0] b;
    wstart(); send(idx, n);
    for (int i = 0; i < 4; i++) begin rd(b); v[8*i +: 8] = b; end
    stop_ev();
  endtask

  task automatic t_reset();
    chk("R12 busy after reset", i2c_busy, 0);
    chk("R12 bus_req after reset", bus_req, 0);
    begin logic [31:0] v; read_reg(8'h00, v); chk("R12 R5 locality after reset", v, 0);
      read_reg(8'h40, v); chk("R12 R9 csum after reset", v, 0); end
  endtask

  task automatic t_index();
    logic n;
    wstart(); send(8'h77, n); chk("R1 unmapped index NAK", n, 1); stop_ev();
    wstart(); send(8'h38, n); chk("R1 address-change index NAK", n, 1); stop_ev();
    wstart(); send(8'h04, n); chk("R1 mapped index ACK", n, 0); stop_ev();
    chk("R3 index-only stop writes nothing", n_wr, 0);
  endtask

  task automatic t_reg_write();
    logic n; int w0;
    w0 = n_wr;
    wstart(); send(8'h04, n); send(8'h11, n); send(8'h22, n); stop_ev();
    chk("R3 one write at stop", n_wr - w0, 1);
    chk("R3 R2 write addr", w_addr, 16'h0000);
    chk("R3 write size", w_size, 4);
    chk("R3 LE data", w_data, 32'h0000_2211);
    wstart(); send(8'h4C, n);
    for (int i = 0; i < 4; i++) send(8'hA0 + 8'(i), n);
    chk("R3 fourth data byte ACK", n, 0);
    send(8'hEE, n); chk("R3 fifth data byte NAK", n, 1);
    stop_ev();
    chk("R3 R2 full write", {w_addr, 16'h0}, {16'h0F04, 16'h0});
    chk("R3 full data", w_data, 32'hA3A2_A1A0);
  endtask

  task automatic t_fifo_write();
    logic n; int w0; bit saw_busy;
    wstart(); send(8'h24, n);
    w0 = n_wr;
    @(negedge clk); i2c_rx_valid = 1; i2c_rx_byte = 8'hAB;
    @(negedge clk); i2c_rx_valid = 0; saw_busy = i2c_busy;
    while (!i2c_rx_done) @(negedge clk);
    chk("R13 busy during FIFO push", saw_busy, 1);
    chk("R4 write before ACK", n_wr - w0, 1);
    chk("R4 FIFO write size", w_size, 1);
    chk("R4 FIFO write data", w_data, 32'hAB);
    chk("R4 R2 FIFO addr", w_addr, 16'h0024);
    send(8'hCD, n);
    chk("R4 second FIFO byte", {n_wr - w0, w_data}, {32'd2, 32'hCD});
    stop_ev();
    chk("R4 no write at stop", n_wr - w0, 2);
  endtask

  task automatic t_locality();
    logic n; logic [31:0] v;
    wstart(); send(8'h00, n); send(8'h03, n); stop_ev();
    read_reg(8'h00, v); chk("R5 locality stored", v, 3);
    wstart(); send(8'h08, n); send(8'hFF, n); send(8'hFF, n); stop_ev();
    chk("R2 locality in address", w_addr, 16'h3008);
    chk("R9 int-enable write mask", w_data, 32'h87);
    wstart(); send(8'h00, n); send(8'h07, n); stop_ev();
    read_reg(8'h00, v); chk("R5 invalid locality ignored", v, 3);
    wstart(); send(8'h00, n); send(8'h00, n); stop_ev();
  endtask

  task automatic t_status();
    logic n; logic [7:0] b; logic [31:0] v;
    wstart(); send(8'h18, n);
    for (int i = 0; i < 4; i++) send(8'hFF, n);
    stop_ev();
    chk("R6 full status write", {w_addr, 13'h0, w_size}, {16'h0018, 13'h0, 3'd4});
    chk("R6 full status mask", w_data, 32'h0300_00FE);
    wstart(); send(8'h1B, n); send(8'hFF, n); stop_ev();
    chk("R6 lane3 status write", {w_addr, 13'h0, w_size}, {16'h001B, 13'h0, 3'd1});
    chk("R6 lane3 mask", w_data, 32'h03);
    be_val = 32'hFFEE_DDCC;
    read_reg(8'h18, v); chk("R7 status read reserved bits", v, 32'h03EE_DDCC);
    wstart(); send(8'h1A, n);
    for (int i = 0; i < 4; i++) begin rd(b); v[8*i +: 8] = b; end
    rd(b);
    stop_ev();
    chk("R7 lane2 shifted read", v, 32'h0000_03EE);
    chk("R8 read past end", b, 0);
  endtask

  task automatic t_reads();
    logic n; logic [7:0] b; logic [31:0] v; int r0;
    be_val = 32'h1234_5678; r0 = n_rd;
    read_reg(8'h48, v);
    chk("R8 cached bytes", v, 32'h1234_5678);
    chk("R8 single backend read", n_rd - r0, 1);
    r0 = n_rd;
    wstart(); send(8'h24, n);
    for (int i = 0; i < 3; i++) begin rd(b); chk("R8 FIFO byte fresh", b, 8'h60 + 8'(i)); end
    stop_ev();
    chk("R8 one read per FIFO byte", n_rd - r0, 3);
    wstart(); send(8'h40, n); send(8'h03, n); stop_ev();
    read_reg(8'h40, v); chk("R9 csum enable bit only", v, 1);
    read_reg(8'h14, v); chk("R9 interrupt capability", v, 32'h87);
    be_val = 32'h0000_0100; read_reg(8'h30, v); chk("R10 burst flag", v, 32'h3A00_0702);
    be_val = 32'h0; read_reg(8'h30, v); chk("R10 base capability", v, 32'h1A00_0702);
  endtask

  task automatic t_clear();
    logic n; logic [7:0] b; int w0;
    stop_ev(); rd(b); chk("R11 read with no index", b, 0); stop_ev();
    wstart(); send(8'h04, n); send(8'h5A, n);
    w0 = n_wr;
    @(negedge clk); i2c_stop = 1; i2c_wr_start = 1;
    @(negedge clk); i2c_stop = 0; i2c_wr_start = 0;
    settle();
    chk("R11 same-cycle stop commits once", n_wr - w0, 1);
    chk("R11 committed data", {w_addr, w_data}, {16'h0000, 32'h5A});
    rd(b); chk("R11 state cleared after stop+start", b, 0);
    stop_ev();
    wstart(); send(8'h04, n); chk("R11 fresh index accepted", n, 0); stop_ev();
    chk("R11 no extra write", n_wr - w0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_index();
    t_reg_write();
    t_fifo_write();
    t_locality();
    t_status();
    t_reads();
    t_clear();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule